// File: doc/BRIEF.md
# APB Requester Transactor with Queued Front End

This block lets a local device issue APB4 transfers without handling the bus phases itself. The device pushes requests into a small queue over a valid/ready handshake. Each request holds an address, a write flag, write data, byte strobes and protection bits. A three-state sequencer drains the queue one transfer at a time. It raises the select line for a setup cycle, then raises the enable line for the access phase, and it holds the access phase until the completer reports ready. The read data and the error flag of every finished transfer go into a second small queue, which the device drains through its own valid/ready handshake.

Only one transfer is in flight at any time, and responses leave in the order the requests came in. When a further request is already queued on the cycle a transfer finishes, the sequencer goes directly into the next setup cycle. The select line stays high across that boundary, so consecutive transfers lose no cycle. The sequencer starts a new transfer only when the response queue is sure to have room for its result. Because of that, a completion is never refused.

Top module: `apb_req_xactor`

## Requirements
- R1: While reset is held and right after it is released, `psel`, `penable` and `rsp_valid` are low and `req_ready` is high.
- R2: When the sequencer is idle and a request is queued, the next cycle is a setup cycle (`psel`=1, `penable`=0). In that cycle `paddr`, `pwrite`, `pwdata`, `pstrb` and `pprot` equal the fields of the oldest queued request. A request accepted at a clock edge reaches setup one cycle later.
- R3: A setup cycle is always followed by an access cycle (`psel`=1, `penable`=1) with the same address, and `penable` is never high without `psel`.
- R4: While `pready` is low in an access cycle, the next cycle is again an access cycle, and the address, write flag and write data do not change.
- R5: Each finished transfer produces exactly one response, in request order. `rsp_rdata` carries `prdata` for a read and zero for a write, and `rsp_err` carries `pslverr`.
- R6: If a request is queued when a transfer finishes, the following cycle is a setup cycle for that request, and `psel` does not drop in between.
- R7: If no request is queued when a transfer finishes, the following cycle has `psel` low.
- R8: The request queue holds two entries. With one transfer stalled in access, exactly three requests are accepted in total, and after that `req_ready` is low. No accepted request is lost.
- R9: The response queue holds two entries. No transfer starts while finishing it could overflow that queue, and transfers resume once the device drains responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and both queues |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered by the local device |
| req_ready | output | 1 | Request queue has room |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Byte strobes for a write |
| req_prot | input | 3 | Protection attributes |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Local device takes the response |
| rsp_rdata | output | DATA_W | Read data, zero for writes |
| rsp_err | output | 1 | Completer reported an error |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (access phase) |
| paddr | output | ADDR_W | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| pstrb | output | DATA_W/8 | APB byte strobes |
| pprot | output | 3 | APB protection |
| pready | input | 1 | Completer ready |
| prdata | input | DATA_W | Completer read data |
| pslverr | input | 1 | Completer error |

## Verification
The hard case is a transfer finishing on the same edge that the next transfer must start. On that edge the sequencer has to push a response, pop a request and load the bus registers together. The bench provokes it by holding `req_valid` high across a run of requests while the completer model inserts a changing number of wait states. Its monitor predicts, from its own count of accepted and started requests, whether the cycle after each completion must be a setup cycle or an idle one. A second collision pairs a completion with a full response queue. That case is driven by holding `rsp_ready` low, and it is judged by counting the setup cycles and by the response order once the queue drains.

// File: rtl/apb_xact_pkg.sv
`timescale 1ns/1ps
package apb_xact_pkg;
  localparam int unsigned PROT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } xact_state_e;
endpackage

// File: rtl/apb_xact_rst_sync.sv
`timescale 1ns/1ps
module apb_xact_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/apb_xact_fifo.sv
`timescale 1ns/1ps
module apb_xact_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [CNT_W-1:0] level
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign in_ready  = (cnt_q < CNT_W'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_q];
  assign level     = cnt_q;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_comb begin
    wr_d  = push ? ptr_inc(wr_q) : wr_q;
    rd_d  = pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_q[wr_q] <= in_data;
    end
  end

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R8
endmodule

// File: rtl/apb_xact_ctrl.sv
`timescale 1ns/1ps
module apb_xact_ctrl
  import apb_xact_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RSP_DEPTH = 2,
  localparam int unsigned STRB_W   = DATA_W / 8,
  localparam int unsigned LVL_W    = $clog2(RSP_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              q_write,
  input  logic [DATA_W-1:0] q_wdata,
  input  logic [STRB_W-1:0] q_strb,
  input  logic [PROT_W-1:0] q_prot,
  output logic              q_pop,
  input  logic [LVL_W-1:0]  rsp_level,
  input  logic              rsp_pop,
  output logic              rsp_push,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [STRB_W-1:0] pstrb,
  output logic [PROT_W-1:0] pprot,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);
  xact_state_e       state_q, state_d;
  logic              load;
  logic              room_idle, room_next;
  logic [LVL_W:0]    lvl_after;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [STRB_W-1:0] strb_q;
  logic [PROT_W-1:0] prot_q;
  logic              done;

  // Room check: idle start needs one free slot now; a start on the
  // completion edge needs a free slot after this completion's push.
  assign lvl_after = ({1'b0, rsp_level} + (LVL_W+1)'(1)) - {{LVL_W{1'b0}}, rsp_pop};
  assign room_idle = (rsp_level < LVL_W'(RSP_DEPTH));
  assign room_next = (lvl_after < (LVL_W+1)'(RSP_DEPTH));
  assign done      = (state_q == ST_ACCESS) && pready;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    rsp_push = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (q_valid && room_idle) begin
          state_d = ST_SETUP;
          load    = 1'b1;
        end
      end
      ST_SETUP: begin
        state_d = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (pready) begin
          rsp_push = 1'b1;
          if (q_valid && room_next) begin
            state_d = ST_SETUP;
            load    = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign q_pop     = load;
  assign rsp_rdata = write_q ? '0 : prdata;
  assign rsp_err   = pslverr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      strb_q  <= '0;
      prot_q  <= '0;
    end else if (load) begin
      addr_q  <= q_addr;
      write_q <= q_write;
      wdata_q <= q_wdata;
      strb_q  <= q_write ? q_strb : '0;
      prot_q  <= q_prot;
    end
  end

  assign psel    = (state_q != ST_IDLE);
  assign penable = (state_q == ST_ACCESS);
  assign paddr   = addr_q;
  assign pwrite  = write_q;
  assign pwdata  = wdata_q;
  assign pstrb   = strb_q;
  assign pprot   = prot_q;

  AST_ENABLE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel); // R3
  AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable && $stable(paddr))); // R3
  AST_WAIT_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr) && $stable(pwdata) && $stable(pwrite))); // R4
  AST_NO_GAP_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && q_valid && room_next) |=> (psel && !penable)); // R6
  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !q_valid) |=> !psel); // R7
  AST_RSP_ROOM_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp_level < LVL_W'(RSP_DEPTH))); // R9
endmodule

// File: rtl/apb_req_xactor.sv
`timescale 1ns/1ps
module apb_req_xactor
  import apb_xact_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REQ_DEPTH = 2,
  parameter int unsigned RSP_DEPTH = 2,
  localparam int unsigned STRB_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [STRB_W-1:0] req_strb,
  input  logic [PROT_W-1:0] req_prot,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [STRB_W-1:0] pstrb,
  output logic [PROT_W-1:0] pprot,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);
  localparam int unsigned REQ_W     = ADDR_W + 1 + DATA_W + STRB_W + PROT_W;
  localparam int unsigned RSP_W     = DATA_W + 1;
  localparam int unsigned REQ_LVL_W = $clog2(REQ_DEPTH + 1);
  localparam int unsigned RSP_LVL_W = $clog2(RSP_DEPTH + 1);

  logic                 rst_sync_n;
  logic [REQ_W-1:0]     req_vec, q_vec;
  logic                 q_valid, q_pop;
  logic [REQ_LVL_W-1:0] req_level;
  logic [RSP_W-1:0]     rsp_in_vec, rsp_out_vec;
  logic                 rsp_push, rsp_in_ready;
  logic [RSP_LVL_W-1:0] rsp_level;
  logic [DATA_W-1:0]    c_rdata;
  logic                 c_err;
  logic [ADDR_W-1:0]    q_addr;
  logic                 q_write;
  logic [DATA_W-1:0]    q_wdata;
  logic [STRB_W-1:0]    q_strb;
  logic [PROT_W-1:0]    q_prot;

  apb_xact_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign req_vec = {req_addr, req_write, req_wdata, req_strb, req_prot};

  apb_xact_fifo #(.WIDTH(REQ_W), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (req_vec),
    .out_valid (q_valid),
    .out_ready (q_pop),
    .out_data  (q_vec),
    .level     (req_level)
  );

  assign {q_addr, q_write, q_wdata, q_strb, q_prot} = q_vec;

  apb_xact_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSP_DEPTH(RSP_DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .q_valid   (q_valid),
    .q_addr    (q_addr),
    .q_write   (q_write),
    .q_wdata   (q_wdata),
    .q_strb    (q_strb),
    .q_prot    (q_prot),
    .q_pop     (q_pop),
    .rsp_level (rsp_level),
    .rsp_pop   (rsp_valid && rsp_ready),
    .rsp_push  (rsp_push),
    .rsp_rdata (c_rdata),
    .rsp_err   (c_err),
    .psel      (psel),
    .penable   (penable),
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .pstrb     (pstrb),
    .pprot     (pprot),
    .pready    (pready),
    .prdata    (prdata),
    .pslverr   (pslverr)
  );

  assign rsp_in_vec = {c_err, c_rdata};

  apb_xact_fifo #(.WIDTH(RSP_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (rsp_push),
    .in_ready  (rsp_in_ready),
    .in_data   (rsp_in_vec),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_out_vec),
    .level     (rsp_level)
  );

  assign {rsp_err, rsp_rdata} = rsp_out_vec;

  AST_NO_RSP_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_push |-> rsp_in_ready); // R9
  AST_REQ_LEVEL_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_level == REQ_LVL_W'(REQ_DEPTH)) |-> !req_ready); // R8
endmodule

// File: tb/apb_req_xactor_tb.sv
`timescale 1ns/1ps
module apb_req_xactor_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_strb;
  logic [2:0]  req_prot;
  logic        rsp_valid, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic        psel, penable, pwrite, pready, pslverr;
  logic [15:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [3:0]  pstrb;
  logic [2:0]  pprot;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_req_xactor u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_strb(req_strb), .req_prot(req_prot),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
    .pstrb(pstrb), .pprot(pprot), .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Completer model: word memory, wait states, error when address bit 7 set.
  logic [31:0] cmem [16];
  logic [31:0] shadow [16];
  int          wait_mode = 0;
  int          c_starts = 0;
  logic [4:0]  wcnt;

  assign pready  = (wcnt == 5'd0);
  assign pslverr = psel && penable && paddr[7];
  assign prdata  = (psel && penable && !paddr[7]) ? cmem[paddr[5:2]] : 32'h0;

  always @(posedge clk) begin
    if (psel && !penable) begin
      wcnt     <= (wait_mode == 4) ? 5'((c_starts * 3 + 1) % 4) : 5'(wait_mode);
      c_starts <= c_starts + 1;
    end else if (psel && penable && wcnt != 5'd0) begin
      wcnt <= wcnt - 5'd1;
    end
    if (psel && penable && pready && pwrite && !paddr[7]) begin
      for (int b = 0; b < 4; b++)
        if (pstrb[b]) cmem[paddr[5:2]][8*b +: 8] <= pwdata[8*b +: 8];
    end
  end

  // Expected per request, in issue order.
  logic [15:0] e_addr  [128];
  logic        e_write [128];
  logic [31:0] e_wdata [128];
  logic [3:0]  e_strb  [128];
  logic [2:0]  e_prot  [128];
  logic [31:0] e_rdata [128];
  logic        e_err   [128];
  int          n_req = 0;
  int          n_rsp = 0;

  // Monitor state
  bit          mon_en = 0;
  bit          flow_en = 1;
  int          hs_total = 0, hs_lag = 0, st_total = 0;
  bit          p_setup = 0, p_wait = 0, p_done = 0, p_psel = 0;
  logic [15:0] p_addr;
  logic [31:0] p_wdata;

  always @(negedge clk) begin
    if (mon_en) begin
      if (p_setup) check(psel && penable && paddr == p_addr, "R3", {penable, paddr}, {1'b1, p_addr});
      if (p_wait)  check(psel && penable && paddr == p_addr && pwdata == p_wdata, "R4", {penable, paddr}, {1'b1, p_addr});
      if (p_done && flow_en) begin
        if (hs_lag > st_total) check(psel && !penable, "R6", {psel, penable}, 2'b10);
        else                   check(!psel, "R7", psel, 0);
      end
      if (!p_psel && flow_en && hs_lag > st_total)
        check(psel && !penable, "R2", {psel, penable}, 2'b10);
      if (psel && !penable) begin
        check(paddr == e_addr[st_total] && pwrite == e_write[st_total] && pwdata == e_wdata[st_total]
              && pprot == e_prot[st_total] && (!pwrite || pstrb == e_strb[st_total]),
              "R2", {paddr, pwrite, pprot}, {e_addr[st_total], e_write[st_total], e_prot[st_total]});
        st_total++;
      end
      if (rsp_valid && rsp_ready) begin
        check(rsp_rdata == e_rdata[n_rsp] && rsp_err == e_err[n_rsp], "R5",
              {rsp_err, rsp_rdata}, {e_err[n_rsp], e_rdata[n_rsp]});
        n_rsp++;
      end
      hs_lag = hs_total;
      if (req_valid && req_ready) hs_total++;
      p_setup = psel && !penable;
      p_wait  = psel && penable && !pready;
      p_done  = psel && penable && pready;
      p_psel  = psel;
      p_addr  = paddr;
      p_wdata = pwdata;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic record(input logic [15:0] a, input logic w, input logic [31:0] d,
                        input logic [3:0] s, input logic [2:0] p);
    e_addr[n_req] = a; e_write[n_req] = w; e_wdata[n_req] = d;
    e_strb[n_req] = s; e_prot[n_req] = p; e_err[n_req] = a[7];
    e_rdata[n_req] = 32'h0;
    if (!a[7]) begin
      if (w) begin
        for (int b = 0; b < 4; b++)
          if (s[b]) shadow[a[5:2]][8*b +: 8] = d[8*b +: 8];
      end else begin
        e_rdata[n_req] = shadow[a[5:2]];
      end
    end
    n_req++;
  endtask

  task automatic send(input logic [15:0] a, input logic w, input logic [31:0] d,
                      input logic [3:0] s, input logic [2:0] p);
    bit acc;
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; req_strb = s; req_prot = p;
    do begin
      @(negedge clk);
      acc = req_ready;
      if (acc) record(a, w, d, s, p);
      @(posedge clk); #1;
    end while (!acc);
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (n_rsp < n_req && guard < 3000) begin cyc(1); guard++; end
    check(n_rsp == n_req, req, n_rsp, n_req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int acc_cnt;
    for (int i = 0; i < 16; i++) begin
      cmem[i] = 32'h01010101 * i;
      shadow[i] = 32'h01010101 * i;
    end
    wcnt = 5'd0;
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    req_addr = '0; req_write = 1'b0; req_wdata = '0; req_strb = '0; req_prot = '0;
    cyc(3);
    @(negedge clk);
    check(!psel && !penable && !rsp_valid && req_ready, "R1", {psel, penable, rsp_valid, req_ready}, 4'b0001);
    rst_n = 1'b1;
    cyc(4);
    @(negedge clk);
    check(!psel && !penable && !rsp_valid && req_ready, "R1", {psel, penable, rsp_valid, req_ready}, 4'b0001);
    @(posedge clk); #1;
    mon_en = 1;

    // Isolated transfers, every wait count, write/read/error kinds.
    for (int w = 0; w < 4; w++) begin
      wait_mode = w;
      for (int k = 0; k < 4; k++) begin
        logic [15:0] a;
        a = (k == 3) ? 16'h0080 | 16'(w << 2) : 16'(((w * 4 + k) % 16) << 2);
        send(a, (k == 0 || k == 3), 32'hA5000000 + 32'(w * 16 + k), 4'(1 << k) | 4'b0001, 3'(k));
        req_valid = 1'b0;
        drain("R5");
        cyc(2);
      end
      send(16'(((w * 4) % 16) << 2), 1'b0, 32'h0, 4'h0, 3'd5);
      req_valid = 1'b0;
      drain("R5");
      cyc(2);
    end

    // Back-to-back stream with varying wait states.
    wait_mode = 4;
    for (int i = 0; i < 16; i++)
      send(16'((i % 8) << 2), (i % 3 == 0), 32'h5A5A0000 + 32'(i), 4'hF - 4'(i % 4), 3'(i));
    req_valid = 1'b0;
    drain("R6");
    cyc(3);

    // Request queue depth with one transfer stalled in access.
    wait_mode = 20;
    acc_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      req_valid = 1'b1; req_addr = 16'((i + 3) << 2); req_write = i[0];
      req_wdata = 32'hC0DE0000 + 32'(i); req_strb = 4'hF; req_prot = 3'd1;
      @(negedge clk);
      if (req_ready) begin
        record(req_addr, req_write, req_wdata, req_strb, req_prot);
        acc_cnt++;
        @(posedge clk); #1;
      end else begin
        @(posedge clk); #1;
        break;
      end
    end
    @(negedge clk);
    check(acc_cnt == 3, "R8", acc_cnt, 3);
    check(!req_ready, "R8", req_ready, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    drain("R8");
    cyc(3);

    // Response queue full: transfers must pause, then resume.
    wait_mode = 0;
    flow_en = 0;
    rsp_ready = 1'b0;
    begin
      int base;
      base = st_total;
      for (int i = 0; i < 4; i++)
        send(16'(i << 2), 1'b0, 32'h0, 4'h0, 3'd2);
      req_valid = 1'b0;
      cyc(12);
      @(negedge clk);
      check(st_total - base == 2, "R9", st_total - base, 2);
      check(!psel && rsp_valid, "R9", {psel, rsp_valid}, 2'b01);
      @(posedge clk); #1;
      rsp_ready = 1'b1;
      drain("R9");
      check(st_total - base == 4, "R9", st_total - base, 4);
    end
    cyc(3);
    flow_en = 1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule